// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a GPIO peripheral for a configurable number of pins, packed 32 to a word across a set of banked registers. A simple register bus writes and reads the per-pin state. The block drives pin output values and output enables. It samples the pin inputs through a two-flop synchronizer and detects a selectable edge on each pin. It latches each detection as a pending status bit and merges all pending bits into a single interrupt line.

Each register kind occupies one region of the address map, and each region holds one 32-bit word per bank. A pin turns into a driven output only when it is both gated on and set to output. The level register always returns the synchronized pin level, whatever the pin's direction. Software acknowledges an interrupt by writing the complement of the pending bits it has serviced: zeros clear bits and ones leave them alone. In the last bank, the bits above the pin count are not pins. They keep whatever software stores in the configuration registers, but they never become pending.

Top module: `pin_bank_ctrl`

## Requirements
- R1: Register code is address bits [ADDR_W-1:ADDR_W-3] (0 gate, 1 output value, 2 direction, 3 level, 4 interrupt mask, 5 pending, 6 rising-edge select, 7 unused and reads 0). The bank index is bits [WSEL_W+1:2], and bits [1:0] are ignored. Pin n is bit n mod 32 of bank n/32.
- R2: After a synchronous reset, direction and mask read all ones, and gate, output value, edge select and pending read zero. pin_oe, irq and bus_rdata are 0.
- R3: pin_out[n] equals the output-value bit of pin n. pin_oe[n] is 1 exactly when the gate bit is 1 and the direction bit is 0 (output).
- R4: The level register returns each pin's input level after a two-flop synchronizer, for input and output pins alike. Writes to it have no effect, and bits above the pin count read 0.
- R5: An edge-select bit of 1 makes a rising edge on that pin set its pending bit. A 0 makes a falling edge set it.
- R6: A pending bit is set only when the pin's gate bit is 1 and its mask bit is 0. A mask bit of 1 blocks the event.
- R7: Writing the pending register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R8: An edge event arriving in the same cycle as a clearing write to its pending bit wins, and the bit stays set.
- R9: In the last bank, bits above the pin count never read pending. The gate, output, direction, mask and edge-select registers hold all 32 written bits.
- R10: irq is 1 in the cycle after any pending bit in any bank is 1, and 0 in the cycle after all are 0.
- R11: bus_rdata loads the addressed word on the clock edge where bus_rd is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address: register code, bank, byte lane |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| pin_out | output | NUM_PINS | Pin output values |
| pin_oe | output | NUM_PINS | Pin output enables |
| irq | output | 1 | Aggregated interrupt |

## Verification
The checker tests the following on every cycle:
- irq tracks the pending bits one cycle late.
- The non-pin bits of the last bank never turn pending.
- A newly pending bit always belonged to a gated, unmasked pin in the cycle before.
- A pending bit only ever drops right after a write to the pending register.
- Reset leaves the outputs quiet.

Only the bench scenarios can show which edge polarity a bit reacts to. They also show the read-back of each register, the mapping of pin numbers onto banks, and that the level register ignores writes. Finally, they show that an edge meeting a clearing write in the same cycle keeps its bit set.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  localparam int WORD_BITS = 32;

  typedef enum logic [2:0] {
    RG_GATE  = 3'd0,
    RG_OUT   = 3'd1,
    RG_DIR   = 3'd2,
    RG_LEVEL = 3'd3,
    RG_MASK  = 3'd4,
    RG_PEND  = 3'd5,
    RG_RISE  = 3'd6,
    RG_NONE  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/pbc_sampler.sv
module pbc_sampler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1, s2, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
    end else begin
      s1   <= din;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign lvl  = s2;
  assign rise = s2 & ~prev;
  assign fall = ~s2 & prev;
endmodule

// File: rtl/pbc_bank.sv
module pbc_bank
  import pbc_pkg::*;
#(
  parameter int VALID = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           we,
  input  logic [WORD_BITS-1:0] wdata,
  input  logic [WORD_BITS-1:0] rise_in,
  input  logic [WORD_BITS-1:0] fall_in,
  output logic [WORD_BITS-1:0] gate,
  output logic [WORD_BITS-1:0] outv,
  output logic [WORD_BITS-1:0] dir,
  output logic [WORD_BITS-1:0] mask,
  output logic [WORD_BITS-1:0] rsel,
  output logic [WORD_BITS-1:0] pend
);
  localparam logic [WORD_BITS-1:0] VMASK =
    (VALID >= WORD_BITS) ? '1 : ((WORD_BITS'(1) << VALID) - WORD_BITS'(1));

  logic [WORD_BITS-1:0] hit, pend_nxt;

  always_comb begin
    hit      = gate & ~mask & ((rsel & rise_in) | (~rsel & fall_in)) & VMASK;
    pend_nxt = (we[RG_PEND] ? (pend & wdata) : pend) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate <= '0;
      outv <= '0;
      dir  <= '1;
      mask <= '1;
      rsel <= '0;
      pend <= '0;
    end else begin
      if (we[RG_GATE]) gate <= wdata;
      if (we[RG_OUT])  outv <= wdata;
      if (we[RG_DIR])  dir  <= wdata;
      if (we[RG_MASK]) mask <= wdata;
      if (we[RG_RISE]) rsel <= wdata;
      pend <= pend_nxt;
    end
  end
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pbc_pkg::*;
#(
  parameter  int NUM_PINS  = 40,
  localparam int NUM_WORDS = (NUM_PINS + WORD_BITS - 1) / WORD_BITS,
  localparam int WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W    = WSEL_W + 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_BITS-1:0] bus_wdata,
  output logic [WORD_BITS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0]  pin_in,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [NUM_PINS-1:0]  pin_oe,
  output logic                 irq
);
  localparam int FLAT = NUM_WORDS * WORD_BITS;

  logic [NUM_PINS-1:0] lvl, rise, fall;
  logic [FLAT-1:0] lvl_f, rise_f, fall_f;
  logic [FLAT-1:0] gate_f, out_f, dir_f, mask_f, rsel_f, pend_f;

  reg_sel_e          a_reg;
  logic [WSEL_W-1:0] a_word;

  assign a_reg  = reg_sel_e'(bus_addr[ADDR_W-1 -: 3]);
  assign a_word = bus_addr[2 +: WSEL_W];

  pbc_sampler #(.W(NUM_PINS)) u_samp (
    .clk(clk), .rst(rst), .din(pin_in),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  assign lvl_f  = FLAT'(lvl);
  assign rise_f = FLAT'(rise);
  assign fall_f = FLAT'(fall);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_bank
    localparam int REM   = NUM_PINS - w * WORD_BITS;
    localparam int VALID = (REM >= WORD_BITS) ? WORD_BITS : REM;
    logic [7:0] we;
    assign we = (bus_wr && a_word == WSEL_W'(w)) ? (8'd1 << a_reg) : 8'd0;

    pbc_bank #(.VALID(VALID)) u_bank (
      .clk(clk), .rst(rst), .we(we), .wdata(bus_wdata),
      .rise_in(rise_f[w*WORD_BITS +: WORD_BITS]),
      .fall_in(fall_f[w*WORD_BITS +: WORD_BITS]),
      .gate(gate_f[w*WORD_BITS +: WORD_BITS]),
      .outv(out_f[w*WORD_BITS +: WORD_BITS]),
      .dir(dir_f[w*WORD_BITS +: WORD_BITS]),
      .mask(mask_f[w*WORD_BITS +: WORD_BITS]),
      .rsel(rsel_f[w*WORD_BITS +: WORD_BITS]),
      .pend(pend_f[w*WORD_BITS +: WORD_BITS])
    );
  end

  assign pin_out = out_f[NUM_PINS-1:0];
  assign pin_oe  = gate_f[NUM_PINS-1:0] & ~dir_f[NUM_PINS-1:0];

  logic [WORD_BITS-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (int'(a_word) < NUM_WORDS) begin
      case (a_reg)
        RG_GATE:  rd_word = gate_f[int'(a_word)*WORD_BITS +: WORD_BITS];
        RG_OUT:   rd_word = out_f[int'(a_word)*WORD_BITS +: WORD_BITS];
        RG_DIR:   rd_word = dir_f[int'(a_word)*WORD_BITS +: WORD_BITS];
        RG_LEVEL: rd_word = lvl_f[int'(a_word)*WORD_BITS +: WORD_BITS];
        RG_MASK:  rd_word = mask_f[int'(a_word)*WORD_BITS +: WORD_BITS];
        RG_PEND:  rd_word = pend_f[int'(a_word)*WORD_BITS +: WORD_BITS];
        RG_RISE:  rd_word = rsel_f[int'(a_word)*WORD_BITS +: WORD_BITS];
        default:  rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_word;
      irq <= |pend_f;
    end
  end
endmodule

// File: rtl/pbc_checker.sv
module pbc_checker #(
  parameter int NUM_PINS = 40,
  parameter int FLAT     = 64,
  parameter int ADDR_W   = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [FLAT-1:0]     pend_f,
  input logic [FLAT-1:0]     gate_f,
  input logic [FLAT-1:0]     mask_f,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq
);
  assert_reset_state_R2: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && !irq));

  assert_irq_follows_pending_R10: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|pend_f));

  assert_event_needs_gate_R6: assert property (@(posedge clk) disable iff (rst)
    ((pend_f & ~$past(pend_f)) & ~($past(gate_f) & ~$past(mask_f))) == '0);

  assert_clear_only_by_write_R7: assert property (@(posedge clk) disable iff (rst)
    (($past(pend_f) & ~pend_f) != '0) |->
      $past(bus_wr && bus_addr[ADDR_W-1 -: 3] == pbc_pkg::RG_PEND));

  if (FLAT > NUM_PINS) begin : g_unused
    assert_unused_no_pending_R9: assert property (@(posedge clk) disable iff (rst)
      pend_f[FLAT-1:NUM_PINS] == '0);
  end
endmodule

bind pin_bank_ctrl pbc_checker #(
  .NUM_PINS(NUM_PINS), .FLAT(FLAT), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .pend_f(pend_f), .gate_f(gate_f), .mask_f(mask_f),
  .pin_oe(pin_oe), .irq(irq)
);

// File: tb/sim_pin_bank_ctrl.sv
`timescale 1ns/1ps
module sim_pin_bank_ctrl;
  localparam int NP = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pin_bank_ctrl #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {write, reg code, bank, write data, expected read-back}
  localparam logic [68:0] VEC [8] = '{
    {1'b1, 3'd0, 1'b0, 32'hA5A5_0F0F, 32'hA5A5_0F0F},  // R1 gate bank0
    {1'b1, 3'd1, 1'b1, 32'h1234_5678, 32'h1234_5678},  // R9 out bank1 keeps all bits
    {1'b1, 3'd6, 1'b1, 32'hFFFF_00FF, 32'hFFFF_00FF},  // R9 edge sel bank1
    {1'b1, 3'd4, 1'b1, 32'h0000_00F0, 32'h0000_00F0},  // R1 mask bank1
    {1'b1, 3'd2, 1'b0, 32'h0000_0000, 32'h0000_0000},  // R1 dir bank0
    {1'b1, 3'd3, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000},  // R4 level ignores write
    {1'b1, 3'd7, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000},  // R1 code 7 reads 0
    {1'b0, 3'd0, 1'b1, 32'h0000_0000, 32'h0000_0000}   // R1 gate bank1 untouched
  };

  function automatic logic [5:0] ad(input logic [2:0] r, input logic w);
    return {r, w, 2'b00};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] r, input logic w, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = ad(r, w); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] r, input logic w, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = ad(r, w);
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; pin_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    @(negedge clk);
    do_reset();

    // R2 reset state
    chk("R2 oe", 64'(pin_oe), 64'h0);
    chk("R2 irq", 64'(irq), 64'h0);
    chk("R2 rdata", 64'(bus_rdata), 64'h0);
    rd(3'd2, 1'b0, d); chk("R2 dir0", 64'(d), 64'hFFFF_FFFF);
    rd(3'd2, 1'b1, d); chk("R2 dir1", 64'(d), 64'hFFFF_FFFF);
    rd(3'd4, 1'b0, d); chk("R2 mask0", 64'(d), 64'hFFFF_FFFF);
    rd(3'd0, 1'b0, d); chk("R2 gate0", 64'(d), 64'h0);
    rd(3'd5, 1'b1, d); chk("R2 pend1", 64'(d), 64'h0);
    rd(3'd6, 1'b0, d); chk("R2 rise0", 64'(d), 64'h0);

    // Table walk: write then read back
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][68]) wr(VEC[i][67:65], VEC[i][64], VEC[i][63:32]);
      rd(VEC[i][67:65], VEC[i][64], d);
      chk("R1/R4/R9 table", 64'(d), 64'(VEC[i][31:0]));
    end

    // R1 low address bits ignored
    bus_wr = 1'b1; bus_addr = 6'b000_0_11; bus_wdata = 32'h0000_00C3;
    @(posedge clk); @(negedge clk); bus_wr = 1'b0;
    rd(3'd0, 1'b0, d); chk("R1 byte lane ignored", 64'(d), 64'hC3);

    // R3 outputs and R1 mapping
    do_reset();
    wr(3'd2, 1'b0, ~32'h1);
    wr(3'd0, 1'b0, 32'h3);
    wr(3'd1, 1'b0, 32'h1);
    wr(3'd2, 1'b1, ~32'h2);
    wr(3'd0, 1'b1, 32'h2);
    chk("R3 oe", 64'(pin_oe), 64'h02_0000_0001);
    chk("R3 out", 64'(pin_out), 64'h00_0000_0001);

    // R4 level for input and output pins
    pin_in = 40'h80_0000_0005;
    settle();
    rd(3'd3, 1'b0, d); chk("R4 level0", 64'(d), 64'h5);
    rd(3'd3, 1'b1, d); chk("R4 level1 upper bits 0", 64'(d), 64'h80);

    // R5/R6 edge polarity, gate and mask
    do_reset();
    wr(3'd0, 1'b0, 32'h1C);         // gate pins 2,3,4
    wr(3'd4, 1'b0, ~32'h2C);        // unmask 2,3,5
    wr(3'd6, 1'b0, 32'h04);         // pin2 rising, others falling
    pin_in[5:2] = 4'hF;
    settle();
    rd(3'd5, 1'b0, d); chk("R5/R6 rising only pin2", 64'(d), 64'h4);
    chk("R10 irq set", 64'(irq), 64'h1);
    pin_in[5:2] = 4'h0;
    settle();
    rd(3'd5, 1'b0, d); chk("R5 falling pin3", 64'(d), 64'hC);

    // R7 clear by zero
    wr(3'd5, 1'b0, ~32'h4);
    rd(3'd5, 1'b0, d); chk("R7 partial clear", 64'(d), 64'h8);
    chk("R10 irq held", 64'(irq), 64'h1);
    wr(3'd5, 1'b0, ~32'h8);
    rd(3'd5, 1'b0, d); chk("R7 full clear", 64'(d), 64'h0);
    chk("R10 irq low", 64'(irq), 64'h0);

    // R8 edge wins over a simultaneous clear
    pin_in[2] = 1'b1; settle();
    pin_in[2] = 1'b0; settle();
    rd(3'd5, 1'b0, d); chk("R8 setup", 64'(d), 64'h4);
    pin_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(3'd5, 1'b0, ~32'h4);
    settle();
    rd(3'd5, 1'b0, d); chk("R8 edge wins", 64'(d), 64'h4);

    // R9 last bank unused bits
    do_reset();
    wr(3'd0, 1'b1, 32'hFFFF_FFFF);
    wr(3'd4, 1'b1, 32'h0);
    wr(3'd6, 1'b1, 32'hFFFF_FFFF);
    pin_in[39] = 1'b1; settle();
    rd(3'd5, 1'b1, d); chk("R9 only pin39 pending", 64'(d), 64'h80);
    rd(3'd0, 1'b1, d); chk("R9 gate1 held", 64'(d), 64'hFFFF_FFFF);

    // R11 read data holds without a read strobe
    rd(3'd6, 1'b1, d);
    wr(3'd6, 1'b1, 32'h0);
    @(negedge clk);
    chk("R11 rdata hold", 64'(bus_rdata), 64'hFFFF_FFFF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule